// File: doc/BRIEF.md
# Stride and Pointer Load Address Predictor

This block watches a small set of repeating loads inside a loop body. Each load has a slot, picked by its position in the loop. For every execution of a load, the block records the address and the data that came back. From these it learns whether the load walks memory with a fixed signed step, keeps reading one address (a step of zero), or follows a chain where each loaded value is the next address. Once a pattern is confirmed, the slot offers a predicted next address, which a pre-executed load buffer can use to fetch ahead.

Predictions are dropped in two cases. A store that writes the predicted address of a slot clears that slot. A mispredict or cancel reported for a slot also clears it. A load whose address disagrees with a confirmed prediction sends the slot back to training. Cache access and re-issue of dependent work are handled outside the block. A combinational query port returns the prediction of any one slot.

Top module: `lap_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no slot reports a valid prediction.
- R2: The first and second loads of a training sequence in a slot never produce a prediction. The second load sets the candidate stride to its address minus the first address, computed modulo 2^32.
- R3: If a slot is training and a load's address equals the previous address plus the candidate stride, the slot becomes confirmed. It then predicts this address plus the stride, with the pointer flag at 0. The prediction changes only when a load, store, mispredict or reset acts on that slot.
- R4: A stride of zero (repeated reads of one address) and negative strides are confirmed and predicted like any other stride, with modular 32-bit arithmetic.
- R5: If the stride check fails, the slot can still confirm in pointer mode. This happens when the data returned by the previous load equals the current address, and the same relation also held between the two loads before it. A slot in pointer mode has the pointer flag at 1 and predicts the data just returned.
- R6: When both the stride check and the pointer check pass on the same load, stride mode is chosen.
- R7: Each of the slots trains and predicts on its own. A load to one slot leaves every other slot unchanged.
- R8: A store whose address equals the prediction of a confirmed slot clears that slot. A store to any other address has no effect.
- R9: A mispredict for a slot clears it. That slot then needs three new loads before it predicts again, and the other slots are unaffected.
- R10: A load to a confirmed slot whose address differs from the prediction clears the prediction. That load becomes the first observation of a new training sequence.
- R11: When a clearing event (store match or mispredict) and a load hit the same slot in the same cycle, the clearing wins and the load is discarded. Events on different slots in the same cycle all take effect.
- R12: The query port returns the valid bit, pointer flag and predicted address of the slot selected by q_slot, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load executed this cycle |
| ld_slot | input | 2 | Loop position of that load |
| ld_addr | input | 32 | Address of the load |
| ld_data | input | 32 | Data returned by the load |
| st_valid | input | 1 | A store executed this cycle |
| st_addr | input | 32 | Address of the store |
| mis_valid | input | 1 | Mispredict or cancel reported |
| mis_slot | input | 2 | Slot the mispredict refers to |
| q_slot | input | 2 | Slot to read out |
| pred_valid | output | 1 | Selected slot holds a confirmed prediction |
| pred_ptr | output | 1 | Selected slot is in pointer mode |
| pred_addr | output | 32 | Predicted next address of the selected slot |

## Verification
A load and a clearing event can arrive in the same cycle, on the same slot or on different slots. The bench confirms a slot and then, in one cycle, sends a load matching its prediction together with a store to that same address. It then checks that the slot reads as cleared and needs three more loads before it predicts. It also sends a matching load to one slot and a mispredict to another in one cycle. It then checks that the first slot's prediction advanced by one stride and the second slot is cleared.

// File: rtl/lap_pkg.sv
package lap_pkg;

    localparam int LAP_AW = 32;

    typedef logic [LAP_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        TR_EMPTY = 2'd0,
        TR_ONE   = 2'd1,
        TR_TWO   = 2'd2,
        TR_LOCK  = 2'd3
    } train_e;

    typedef struct packed {
        train_e st;
        logic   ptr;
        logic   ptr_cand;
        addr_t  last_addr;
        addr_t  last_data;
        addr_t  stride;
    } slot_t;

    function automatic addr_t pred_of(slot_t s);
        return s.ptr ? s.last_data : (s.last_addr + s.stride);
    endfunction

endpackage

// File: rtl/lap_slot.sv
module lap_slot
    import lap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_hit,
    input  addr_t ld_addr,
    input  addr_t ld_data,
    input  logic  st_valid,
    input  addr_t st_addr,
    input  logic  mis_hit,
    output logic  vld,
    output logic  ptr,
    output addr_t pred
);

    slot_t cur, nxt;
    addr_t cand;
    logic  stride_ok, ptr_ok, kill;

    assign cand      = ld_addr - cur.last_addr;
    assign stride_ok = (ld_addr == cur.last_addr + cur.stride);
    assign ptr_ok    = (ld_addr == cur.last_data);
    assign pred      = pred_of(cur);
    assign vld       = (cur.st == TR_LOCK);
    assign ptr       = cur.ptr;
    assign kill      = mis_hit | (st_valid && vld && (st_addr == pred));

    always_comb begin
        nxt = cur;
        if (ld_hit) begin
            nxt.last_addr = ld_addr;
            nxt.last_data = ld_data;
            unique case (cur.st)
                TR_EMPTY: nxt.st = TR_ONE;
                TR_ONE: begin
                    nxt.st       = TR_TWO;
                    nxt.stride   = cand;
                    nxt.ptr_cand = ptr_ok;
                end
                TR_TWO: begin
                    if (stride_ok) begin
                        nxt.st  = TR_LOCK;
                        nxt.ptr = 1'b0;
                    end else if (cur.ptr_cand && ptr_ok) begin
                        nxt.st  = TR_LOCK;
                        nxt.ptr = 1'b1;
                    end else begin
                        nxt.stride   = cand;
                        nxt.ptr_cand = ptr_ok;
                    end
                end
                TR_LOCK: begin
                    if (ld_addr != pred) begin
                        nxt.st  = TR_ONE;
                        nxt.ptr = 1'b0;
                    end
                end
                default: nxt.st = TR_EMPTY;
            endcase
        end
        if (kill) begin
            nxt          = cur;
            nxt.st       = TR_EMPTY;
            nxt.ptr      = 1'b0;
            nxt.ptr_cand = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lap_read_mux.sv
module lap_read_mux
    import lap_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic [SW-1:0]             sel,
    input  logic [NSLOT-1:0]          vld_v,
    input  logic [NSLOT-1:0]          ptr_v,
    input  logic [NSLOT-1:0][LAP_AW-1:0] pred_v,
    output logic                      o_vld,
    output logic                      o_ptr,
    output addr_t                     o_pred
);

    assign o_vld  = vld_v[sel];
    assign o_ptr  = ptr_v[sel];
    assign o_pred = pred_v[sel];

endmodule

// File: rtl/lap_top.sv
module lap_top
    import lap_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [SW-1:0]     ld_slot,
    input  logic [LAP_AW-1:0] ld_addr,
    input  logic [LAP_AW-1:0] ld_data,
    input  logic              st_valid,
    input  logic [LAP_AW-1:0] st_addr,
    input  logic              mis_valid,
    input  logic [SW-1:0]     mis_slot,
    input  logic [SW-1:0]     q_slot,
    output logic              pred_valid,
    output logic              pred_ptr,
    output logic [LAP_AW-1:0] pred_addr
);

    logic [NSLOT-1:0]             slot_vld;
    logic [NSLOT-1:0]             slot_ptr;
    logic [NSLOT-1:0][LAP_AW-1:0] slot_pred;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        lap_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .ld_hit   (ld_valid && (ld_slot == SW'(i))),
            .ld_addr  (ld_addr),
            .ld_data  (ld_data),
            .st_valid (st_valid),
            .st_addr  (st_addr),
            .mis_hit  (mis_valid && (mis_slot == SW'(i))),
            .vld      (slot_vld[i]),
            .ptr      (slot_ptr[i]),
            .pred     (slot_pred[i])
        );
    end

    lap_read_mux #(.NSLOT(NSLOT)) u_mux (
        .sel    (q_slot),
        .vld_v  (slot_vld),
        .ptr_v  (slot_ptr),
        .pred_v (slot_pred),
        .o_vld  (pred_valid),
        .o_ptr  (pred_ptr),
        .o_pred (pred_addr)
    );

endmodule

// File: rtl/lap_chk.sv
module lap_chk
    import lap_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = $clog2(NSLOT)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ld_valid,
    input logic [SW-1:0]             ld_slot,
    input logic                      st_valid,
    input logic [LAP_AW-1:0]         st_addr,
    input logic                      mis_valid,
    input logic [SW-1:0]             mis_slot,
    input logic [NSLOT-1:0]          slot_vld,
    input logic [NSLOT-1:0][LAP_AW-1:0] slot_pred
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (slot_vld == '0));

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        // R9
        mis_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (mis_valid && mis_slot == SW'(i)) |=> !slot_vld[i]);

        // R8
        store_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (st_valid && slot_vld[i] && slot_pred[i] == st_addr) |=> !slot_vld[i]);

        // R3
        confirm_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(slot_vld[i]) |-> $past(ld_valid && ld_slot == SW'(i)));

        // R3
        pred_holds_chk: assert property (@(posedge clk) disable iff (rst)
            (slot_vld[i] && !(ld_valid && ld_slot == SW'(i)))
                |=> (!slot_vld[i] || $stable(slot_pred[i])));
    end

endmodule

bind lap_top lap_chk #(.NSLOT(NSLOT)) u_lap_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_slot   (ld_slot),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .mis_valid (mis_valid),
    .mis_slot  (mis_slot),
    .slot_vld  (slot_vld),
    .slot_pred (slot_pred)
);

// File: tb/test_lap_top.sv
module test_lap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_slot = '0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        mis_valid = 1'b0;
    logic [1:0]  mis_slot = '0;
    logic [1:0]  q_slot = '0;
    logic        pred_valid;
    logic        pred_ptr;
    logic [31:0] pred_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    lap_top i_lap_top (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_addr(ld_addr), .ld_data(ld_data),
        .st_valid(st_valid), .st_addr(st_addr),
        .mis_valid(mis_valid), .mis_slot(mis_slot),
        .q_slot(q_slot),
        .pred_valid(pred_valid), .pred_ptr(pred_ptr), .pred_addr(pred_addr)
    );

    task automatic chk(string req, int s, logic v, logic p, logic [31:0] a);
        q_slot = 2'(s);
        #1;
        total++;
        if (pred_valid !== v || (v && (pred_ptr !== p || pred_addr !== a))) begin
            bad++;
            $display("FAIL %s slot=%0d got v=%b p=%b a=%h exp v=%b p=%b a=%h",
                     req, s, pred_valid, pred_ptr, pred_addr, v, p, a);
        end
    endtask

    task automatic load(int s, logic [31:0] a, logic [31:0] d);
        ld_valid = 1'b1; ld_slot = 2'(s); ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic store(logic [31:0] a);
        st_valid = 1'b1; st_addr = a;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic mispredict(int s);
        mis_valid = 1'b1; mis_slot = 2'(s);
        @(negedge clk);
        mis_valid = 1'b0;
    endtask

    logic [31:0] strides [6] = '{32'd0, 32'd4, -32'sd4, 32'd1, -32'sd1000, 32'd64};

    initial begin
        logic [31:0] base, a, pp;
        logic [31:0] ptab [6];
        repeat (2) @(negedge clk);
        for (int s = 0; s < 4; s++) chk("R1", s, 1'b0, 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) chk("R1", s, 1'b0, 1'b0, '0);

        // stride sweep: every slot, several strides, five loads each
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 6; j++) begin
                base = 32'h1000_0000 * (s + 1) + 32'h0010_0000 * j;
                for (int k = 1; k <= 5; k++) begin
                    a = base + strides[j] * (k - 1);
                    load(s, a, 32'hFFFF_0000 + k);
                    if (k < 3)
                        chk("R2", s, 1'b0, 1'b0, '0);
                    else if (strides[j] == 0 || strides[j][31])
                        chk("R4", s, 1'b1, 1'b0, a + strides[j]);
                    else
                        chk("R3", s, 1'b1, 1'b0, a + strides[j]);
                end
            end
        end

        // interleaved slots
        for (int r = 1; r <= 4; r++) begin
            for (int s = 0; s < 4; s++)
                load(s, 32'h8000_0000 + 32'h0100_0000 * s + 8 * (s + 1) * (r - 1), 32'h0);
            for (int s = 0; s < 4; s++)
                chk("R7 R12", s, r >= 3, 1'b0,
                    32'h8000_0000 + 32'h0100_0000 * s + 8 * (s + 1) * r);
        end

        // stores: non-matching then matching
        store(32'h8000_0020 + 4);
        for (int s = 0; s < 4; s++)
            chk("R8", s, 1'b1, 1'b0, 32'h8000_0000 + 32'h0100_0000 * s + 32 * (s + 1));
        store(32'h8000_0020);
        chk("R8", 0, 1'b0, 1'b0, '0);
        chk("R8", 1, 1'b1, 1'b0, 32'h8100_0040);

        // mispredict and retrain
        mispredict(2);
        chk("R9", 2, 1'b0, 1'b0, '0);
        chk("R9", 3, 1'b1, 1'b0, 32'h8300_0080);
        load(2, 32'hB000_0000, 32'h0); chk("R9", 2, 1'b0, 1'b0, '0);
        load(2, 32'hB000_0040, 32'h0); chk("R9", 2, 1'b0, 1'b0, '0);
        load(2, 32'hB000_0080, 32'h0); chk("R9", 2, 1'b1, 1'b0, 32'hB000_00C0);

        // pointer chase on slot 0 (cleared)
        ptab = '{32'h5000, 32'h5230, 32'h5010, 32'h7000, 32'h5444, 32'h6000};
        for (int k = 0; k < 5; k++) begin
            load(0, ptab[k], ptab[k + 1]);
            if (k < 2) chk("R5", 0, 1'b0, 1'b0, '0);
            else       chk("R5", 0, 1'b1, 1'b1, ptab[k + 1]);
        end

        // stride beats pointer
        mispredict(1);
        pp = 32'h9000_0000;
        load(1, pp,     pp + 4);
        load(1, pp + 4, pp + 8);
        load(1, pp + 8, 32'h1234_5678);
        chk("R6", 1, 1'b1, 1'b0, pp + 12);

        // mismatching load in confirmed slot 3
        load(3, 32'hA000_0000, 32'h0); chk("R10", 3, 1'b0, 1'b0, '0);
        load(3, 32'hA000_0008, 32'h0); chk("R10", 3, 1'b0, 1'b0, '0);
        load(3, 32'hA000_0010, 32'h0); chk("R10", 3, 1'b1, 1'b0, 32'hA000_0018);

        // same-cycle: matching load and matching store on slot 3
        ld_valid = 1'b1; ld_slot = 2'd3; ld_addr = 32'hA000_0018; ld_data = '0;
        st_valid = 1'b1; st_addr = 32'hA000_0018;
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0;
        chk("R11", 3, 1'b0, 1'b0, '0);
        load(3, 32'hA000_0020, 32'h0); chk("R11", 3, 1'b0, 1'b0, '0);
        load(3, 32'hA000_0028, 32'h0); chk("R11", 3, 1'b0, 1'b0, '0);
        load(3, 32'hA000_0030, 32'h0); chk("R11", 3, 1'b1, 1'b0, 32'hA000_0038);

        // same-cycle: load slot 2, mispredict slot 3
        ld_valid = 1'b1; ld_slot = 2'd2; ld_addr = 32'hB000_00C0; ld_data = '0;
        mis_valid = 1'b1; mis_slot = 2'd3;
        @(negedge clk);
        ld_valid = 1'b0; mis_valid = 1'b0;
        chk("R11", 2, 1'b1, 1'b0, 32'hB000_0100);
        chk("R11", 3, 1'b0, 1'b0, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule